// File: doc/BRIEF.md
# Multiplexed-Address DRAM Device Model

This block is a synthesizable clocked stand-in for an asynchronous dynamic RAM whose row and column addresses share one set of pins. A system clock samples four active-low strobes: row strobe, column strobe, write enable and output enable. Each strobe passes through a two-flop synchronizer before edge detection. The address and write-data inputs are delayed by the same two flops, so they stay aligned with the strobes.

A falling row strobe latches the row address and opens that row. Opening a row copies it into a row buffer and clears it in storage, which models a destructive read. Each later falling column strobe selects one word of the open row. Reads and writes act only on the buffer. When the row strobe rises, the buffer is written back to storage and the access ends. Several column cycles may run under one row strobe. A write happens either at the column edge, when write enable is already low, or at a later falling edge of write enable. The data bus is split into an input, an output and an output-enable.

Top module: `mxdram_model`

## Requirements
- R1: After reset, dout_en_o is 0, dout_o is 0 and every stored word reads back as 0.
- R2: A falling ras_ni latches addr_i as the row. A falling cas_ni while the row is open latches addr_i as the column. A read then returns the word stored at that row and column.
- R3: dout_en_o is 1 only while a column is latched in an open row, we_ni is high and oe_ni is low. Otherwise dout_en_o is 0 and dout_o is 0. With we_ni and oe_ni both low, nothing is driven.
- R4: Early write: if we_ni is already low when cas_ni falls, din_i is written to the word just selected.
- R5: Late write: if we_ni falls while cas_ni is low after a column was latched, din_i at that moment is written to the latched column.
- R6: Page mode: while ras_ni stays low, each new cas_ni fall selects a new column of the same row, for both reads and writes.
- R7: A rising ras_ni writes the row buffer back to storage. Contents therefore survive any number of reads and reopenings of the row.
- R8: A cas_ni fall while no row is open is ignored. It causes no output and no write, even with we_ni low.
- R9: Read data stays on dout_o until cas_ni or oe_ni rises. If oe_ni falls after cas_ni, output begins only then.
- R10: Pin changes act through a two-flop synchronizer. A read started by a cas_ni fall shows on dout_en_o no earlier than the third rising clock edge after the change, and by the fourth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | AW | Shared row/column address |
| din_i | input | DW | Write data |
| dout_o | output | DW | Read data, 0 when not driven |
| dout_en_o | output | 1 | Read data valid / bus drive enable |

## Verification
Faults in the row/column latches or in the row buffer show up as wrong read data during the same access. A missing write-back or restore stays hidden until the row is reopened. The bench therefore reopens rows and repeats reads across separate accesses. A wrong column-valid or open-row flag shows as dout_en_o asserting or releasing at the wrong moment. That is visible within four clock edges of the strobe change that should have caused it.

// File: rtl/mxdram_pkg.sv
package mxdram_pkg;
  typedef struct packed {
    logic ras;
    logic cas;
    logic we;
    logic oe;
  } strb_t;

  localparam strb_t STRB_IDLE = '{ras: 1'b1, cas: 1'b1, we: 1'b1, oe: 1'b1};
endpackage

// File: rtl/mxdram_sync.sv
module mxdram_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, stab_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      stab_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/mxdram_array.sv
module mxdram_array #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [AW-1:0]             rd_row_i,
  output logic [(1<<AW)*DW-1:0]     rd_data_o,
  input  logic                      clr_en_i,
  input  logic [AW-1:0]             clr_row_i,
  input  logic                      wb_en_i,
  input  logic [AW-1:0]             wb_row_i,
  input  logic [(1<<AW)*DW-1:0]     wb_data_i
);
  localparam int ROWS = 1 << AW;
  localparam int RW   = ROWS * DW;

  logic [RW-1:0] mem_q [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        mem_q[r] <= '0;
      else if (wb_en_i && wb_row_i == AW'(r))
        mem_q[r] <= wb_data_i;
      else if (clr_en_i && clr_row_i == AW'(r))
        mem_q[r] <= '0;  // destructive open
    end
  end

  assign rd_data_o = mem_q[rd_row_i];

  // R7
  wb_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_i |=> mem_q[$past(wb_row_i)] == $past(wb_data_i));

  // R7
  open_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_i && !wb_en_i) |=> mem_q[$past(clr_row_i)] == '0);
endmodule

// File: rtl/mxdram_rowbuf.sv
module mxdram_rowbuf #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_en_i,
  input  logic [(1<<AW)*DW-1:0]     load_data_i,
  input  logic                      wr_en_i,
  input  logic [AW-1:0]             wr_col_i,
  input  logic [DW-1:0]             wr_data_i,
  input  logic [AW-1:0]             rd_col_i,
  output logic [DW-1:0]             rd_data_o,
  output logic [(1<<AW)*DW-1:0]     row_o
);
  localparam int COLS = 1 << AW;

  logic [DW-1:0] word_q [COLS];

  for (genvar c = 0; c < COLS; c++) begin : g_col
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        word_q[c] <= '0;
      else if (load_en_i)
        word_q[c] <= load_data_i[c*DW +: DW];
      else if (wr_en_i && wr_col_i == AW'(c))
        word_q[c] <= wr_data_i;
    end
    assign row_o[c*DW +: DW] = word_q[c];
  end

  assign rd_data_o = word_q[rd_col_i];

  // R4
  buf_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !load_en_i) |=> word_q[$past(wr_col_i)] == $past(wr_data_i));
endmodule

// File: rtl/mxdram_model.sv
module mxdram_model #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ras_ni,
  input  logic          cas_ni,
  input  logic          we_ni,
  input  logic          oe_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] dout_o,
  output logic          dout_en_o
);
  import mxdram_pkg::*;

  localparam int COLS = 1 << AW;
  localparam int RW   = COLS * DW;
  localparam int PW   = AW + DW;

  strb_t         strb_raw, strb_s, strb_p;
  logic [PW-1:0] pay_s;
  logic [AW-1:0] addr_s;
  logic [DW-1:0] din_s;

  assign strb_raw = '{ras: ras_ni, cas: cas_ni, we: we_ni, oe: oe_ni};

  mxdram_sync #(.W($bits(strb_t)), .RST_VAL(STRB_IDLE)) u_strb_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (strb_raw), .q_o (strb_s)
  );

  mxdram_sync #(.W(PW), .RST_VAL('0)) u_pay_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i ({addr_i, din_i}), .q_o (pay_s)
  );

  assign {addr_s, din_s} = pay_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strb_p <= STRB_IDLE;
    else         strb_p <= strb_s;
  end

  logic ras_fall, ras_rise, cas_fall, cas_rise, we_fall;
  assign ras_fall = strb_p.ras & ~strb_s.ras;
  assign ras_rise = ~strb_p.ras & strb_s.ras;
  assign cas_fall = strb_p.cas & ~strb_s.cas;
  assign cas_rise = ~strb_p.cas & strb_s.cas;
  assign we_fall  = strb_p.we & ~strb_s.we;

  logic          open_q, colv_q;
  logic [AW-1:0] row_q, col_q;
  logic          col_take, early_wr, late_wr;

  assign col_take = cas_fall & open_q & ~ras_rise;
  assign early_wr = col_take & ~strb_s.we;
  assign late_wr  = we_fall & colv_q & ~strb_s.cas & ~ras_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      colv_q <= 1'b0;
      row_q  <= '0;
      col_q  <= '0;
    end else begin
      if (ras_rise) begin
        open_q <= 1'b0;
        colv_q <= 1'b0;
      end else begin
        if (ras_fall) begin
          open_q <= 1'b1;
          row_q  <= addr_s;
        end
        if (col_take) begin
          colv_q <= 1'b1;
          col_q  <= addr_s;
        end else if (cas_rise) begin
          colv_q <= 1'b0;
        end
      end
    end
  end

  logic [RW-1:0] arr_row, buf_row;
  logic [DW-1:0] buf_word;
  logic          buf_load;

  assign buf_load = ras_fall & ~open_q;

  mxdram_array #(.AW(AW), .DW(DW)) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_row_i  (addr_s),
    .rd_data_o (arr_row),
    .clr_en_i  (buf_load),
    .clr_row_i (addr_s),
    .wb_en_i   (ras_rise & open_q),
    .wb_row_i  (row_q),
    .wb_data_i (buf_row)
  );

  mxdram_rowbuf #(.AW(AW), .DW(DW)) u_rowbuf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_en_i   (buf_load),
    .load_data_i (arr_row),
    .wr_en_i     (early_wr | late_wr),
    .wr_col_i    (col_take ? addr_s : col_q),
    .wr_data_i   (din_s),
    .rd_col_i    (col_q),
    .rd_data_o   (buf_word),
    .row_o       (buf_row)
  );

  logic          drive_d;
  logic          en_q;
  logic [DW-1:0] dat_q;

  assign drive_d = open_q & colv_q & strb_s.we & ~strb_s.oe;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      dat_q <= '0;
    end else begin
      en_q  <= drive_d;
      dat_q <= drive_d ? buf_word : '0;
    end
  end

  assign dout_en_o = en_q;
  assign dout_o    = dat_q;

  // R2
  row_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ras_fall && !open_q) |=> (open_q && row_q == $past(addr_s)));

  // R7
  close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ras_rise |=> (!open_q && !colv_q));

  // R8
  stray_cas_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cas_fall && !open_q && !colv_q) |=> !colv_q);

  // R3
  drive_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_en_o |-> $past(open_q));

  // R3
  quiet_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dout_en_o |-> dout_o == '0);
endmodule

// File: tb/mxdram_model_tb.sv
`timescale 1ns/1ps
module mxdram_model_tb;
  localparam int AW = 4;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dout_en;

  always #4 clk = ~clk;

  mxdram_model #(.AW(AW), .DW(DW)) u_dut (
    .clk_i (clk), .rst_ni (rst_n), .ras_ni (ras_n), .cas_ni (cas_n),
    .we_ni (we_n), .oe_ni (oe_n), .addr_i (addr), .din_i (din),
    .dout_o (dout), .dout_en_o (dout_en)
  );

  typedef struct {
    logic          en;
    logic [DW-1:0] data;
    string         req;
  } exp_t;

  exp_t exp_q[$];
  event mon_ev;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  // monitor: pops expectations and compares against the bus
  initial forever begin
    @(mon_ev);
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_chk++;
      if (dout_en !== e.en || dout !== e.data) begin
        n_fail++;
        $display("FAIL %s: en/data = %0b/%02h expected %0b/%02h",
                 e.req, dout_en, dout, e.en, e.data);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_bus(logic en, logic [DW-1:0] d, string req);
    exp_t e;
    e.en = en; e.data = en ? d : '0; e.req = req;
    exp_q.push_back(e);
    -> mon_ev;
    #0.1;
  endtask

  task automatic open_row(logic [AW-1:0] r);
    addr = r; tick(1); ras_n = 1'b0; tick(5);
  endtask

  task automatic close_row();
    cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; tick(2); ras_n = 1'b1; tick(5);
  endtask

  task automatic read_col(logic [AW-1:0] c, logic [DW-1:0] d, string req);
    addr = c; we_n = 1'b1; oe_n = 1'b0; tick(1);
    cas_n = 1'b0; tick(5);
    expect_bus(1'b1, d, req);
    cas_n = 1'b1; tick(5);
    expect_bus(1'b0, '0, req);
    oe_n = 1'b1; tick(1);
  endtask

  task automatic early_write(logic [AW-1:0] c, logic [DW-1:0] d);
    addr = c; din = d; we_n = 1'b0; oe_n = 1'b1; tick(1);
    cas_n = 1'b0; tick(5);
    cas_n = 1'b1; tick(1); we_n = 1'b1; tick(4);
  endtask

  task automatic late_write(logic [AW-1:0] c, logic [DW-1:0] d);
    addr = c; we_n = 1'b1; oe_n = 1'b1; tick(1);
    cas_n = 1'b0; tick(5);
    din = d; tick(1); we_n = 1'b0; tick(5);
    expect_bus(1'b0, '0, "R5 no drive during late write");
    cas_n = 1'b1; tick(1); we_n = 1'b1; tick(4);
  endtask

  initial begin
    tick(3);
    expect_bus(1'b0, '0, "R1 reset bus");
    rst_n = 1'b1; tick(3);
    expect_bus(1'b0, '0, "R1 idle after reset");

    // R1: unwritten word is zero
    open_row(4'd5); read_col(4'd3, 8'h00, "R1 stored zero"); close_row();

    // R4 / R2 early writes to two rows
    open_row(4'd2); early_write(4'd7, 8'hA5); close_row();
    open_row(4'd9); early_write(4'd7, 8'h3C); close_row();
    open_row(4'd2); read_col(4'd7, 8'hA5, "R4 early write row 2"); close_row();
    open_row(4'd9); read_col(4'd7, 8'h3C, "R2 row select row 9"); close_row();

    // R5 late write
    open_row(4'd4); late_write(4'd1, 8'h5E); close_row();
    open_row(4'd4); read_col(4'd1, 8'h5E, "R5 late write"); close_row();

    // R6 page mode: writes then reads in one access each
    open_row(4'd12);
    for (int i = 0; i < 4; i++) early_write(4'(i * 3), 8'(8'h10 + i));
    read_col(4'd6, 8'h12, "R6 page read within write access");
    close_row();
    open_row(4'd12);
    for (int i = 0; i < 4; i++) read_col(4'(i * 3), 8'(8'h10 + i), "R6 page read");
    close_row();

    // R7 restore across repeated opens
    for (int k = 0; k < 3; k++) begin
      open_row(4'd2); read_col(4'd7, 8'hA5, "R7 restore after reread");
      read_col(4'd7, 8'hA5, "R7 second read same access"); close_row();
    end
    open_row(4'd15); early_write(4'd15, 8'hFF); early_write(4'd0, 8'h01); close_row();
    open_row(4'd15); read_col(4'd15, 8'hFF, "R7 corner word"); read_col(4'd0, 8'h01, "R7 corner word 0"); close_row();

    // R8 column strobe with no open row
    addr = 4'd7; din = 8'hEE; we_n = 1'b0; tick(1); cas_n = 1'b0; tick(5);
    expect_bus(1'b0, '0, "R8 no output without row");
    we_n = 1'b1; oe_n = 1'b0; tick(5);
    expect_bus(1'b0, '0, "R8 no read without row");
    cas_n = 1'b1; oe_n = 1'b1; tick(5);
    open_row(4'd2); read_col(4'd7, 8'hA5, "R8 word untouched"); close_row();

    // R9 late output enable and hold
    open_row(4'd9); addr = 4'd7; we_n = 1'b1; oe_n = 1'b1; tick(1);
    cas_n = 1'b0; tick(5);
    expect_bus(1'b0, '0, "R9 no output before oe");
    oe_n = 1'b0; tick(5);
    expect_bus(1'b1, 8'h3C, "R9 output after late oe");
    addr = 4'd0; tick(8);
    expect_bus(1'b1, 8'h3C, "R9 held while cas low");
    oe_n = 1'b1; tick(5);
    expect_bus(1'b0, '0, "R9 release on oe rise");
    // R3 both enables low: no drive
    oe_n = 1'b0; we_n = 1'b0; din = 8'h3C; tick(5);
    expect_bus(1'b0, '0, "R3 we and oe both low");
    close_row();

    // R10 latency of a read
    open_row(4'd4); addr = 4'd1; oe_n = 1'b0; tick(1);
    cas_n = 1'b0; tick(2);
    expect_bus(1'b0, '0, "R10 not before third edge");
    tick(2);
    expect_bus(1'b1, 8'h5E, "R10 by fourth edge");
    close_row();
    tick(3);
    expect_bus(1'b0, '0, "R3 idle after close");

    done = 1'b1;
    tick(2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: timeout reached expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule